// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a serial-bus target that holds a small bank of byte-wide configuration registers. A host reaches the registers only through indexed block transfers. In a write, the host names a starting register, states how many data bytes follow, and then sends them. In a read, the host first sends a short write that carries only the starting register. It then issues a repeated start with the read form of the address and receives a length byte followed by register contents.

The block samples the clock and data lines through a synchronizer that runs on the system clock. It pulls the data line low through an open-drain enable and changes that enable only while the bus clock is low. The register contents are also presented in parallel on a flat output vector so that the surrounding chip can use them as configuration.

Top module: `smb_regbank`

## Requirements
- R1: The address byte 0xD2 (write form) and 0xD3 (read form) are acknowledged. Any other address byte is not acknowledged. After a non-matching address, the block leaves SDA released for every following bit, acknowledges nothing and stores nothing until the next start condition.
- R2: In a write, the index byte and the count byte are each acknowledged. Data bytes k = 0 .. X-1 are each acknowledged and stored into register (N+k).
- R3: The running register index wraps from 15 back to 0, for both writes and reads.
- R4: An index byte of 16 or more is acknowledged. The data bytes that follow it are acknowledged and discarded, and a read from such an index returns 0x00 for every data byte.
- R5: A data byte beyond the announced count X is not acknowledged and is not stored. A count of 0 means that no data byte is accepted.
- R6: After 0xD3 is acknowledged, the block sends, most significant bit first, the length byte and then registers N, N+1, ... for as long as the host acknowledges. After a host NACK it releases SDA and drives nothing until the next start.
- R7: The length byte sent in a read is the content of register 8. Register 8 is written like any other register.
- R8: After reset, all registers read 0x00 except register 8, which reads 0x08, and SDA is released.
- R9: The SDA drive enable changes only while the synchronized SCL is low.
- R10: A start or stop condition that arrives inside a byte ends the transfer. The partial byte is not stored, bytes completed earlier in that transfer remain stored, and a following transfer works normally.
- R11: The output cfg_flat carries register k on bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_flat | output | 128 | All registers in parallel, register k on bits [8k+7:8k] |

## Verification
Two events can arrive close together: the completion of a data byte, which commits a register write, and a start or stop condition that ends the transfer. The bench provokes this by cutting bytes off halfway with a stop or a repeated start, immediately after a fully received byte. It then reads the bank back and requires that the completed byte is present and that the cut-off byte left its target register unchanged. The second pairing is the host's NACK on a read byte followed at once by a stop. Here the bench checks that SDA is released during the following bits and that a fresh read still returns the correct length byte and data.

// File: rtl/smb_pkg.sv
// Package: shared types for the indexed register slave.
// Assumes: imported by the protocol engine and its parent.
package smb_pkg;

    // Transfer phase tracked by the protocol engine.
    typedef enum logic [2:0] {
        PH_IDLE,    // waiting for a start condition
        PH_ADDR,    // receiving the address byte
        PH_INDEX,   // receiving the start index
        PH_COUNT,   // receiving the byte count of a write
        PH_WDATA,   // receiving write data
        PH_TXCNT,   // sending the length byte
        PH_TXDATA,  // sending register data
        PH_SKIP     // ignoring the bus until the next start
    } phase_t;

endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings SCL and SDA into the system clock domain through a flop chain and
// derives clock edges plus start and stop conditions from the synchronized
// lines.
// Assumes: the system clock is many times faster than SCL, and the bus idles high.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_p;
    logic              sda_p;

    assign raw = {sda_i, scl_i};

    // One synchronizer chain per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the line through the chain; reset to the idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end

        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[0];
    assign sda_s = synced[1];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/smb_bit_engine.sv
// Module: smb_bit_engine
// Shifts bits in on SCL rising edges and out on SCL falling edges. It runs the
// acknowledge slot after every eighth bit, pulses byte_done when a byte has
// been collected, and reports the host acknowledge for bytes that it sent.
// Assumes: SCL edge strobes are single-cycle pulses. ack_req and tx_next are
// stable by the SCL falling edge that follows byte_done or host_ack_v.
module smb_bit_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       ack_req,
    input  logic       tx_next,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       host_ack_v,
    output logic       host_ack,
    output logic       sda_oe
);
    localparam int BITS  = 8;
    localparam int CNT_W = $clog2(BITS + 1);

    logic [CNT_W-1:0] bit_cnt;
    logic             in_ack;
    logic             sending;
    logic [7:0]       sh_rx;
    logic [7:0]       sh_tx;
    logic             drive;

    // Bit counting, shifting and acknowledge-slot control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            in_ack     <= 1'b0;
            sending    <= 1'b0;
            sh_rx      <= '0;
            sh_tx      <= '0;
            drive      <= 1'b0;
            byte_done  <= 1'b0;
            host_ack_v <= 1'b0;
            host_ack   <= 1'b0;
        end else begin
            byte_done  <= 1'b0;
            host_ack_v <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sending <= 1'b0;
                drive   <= 1'b0;
            end else if (scl_rise) begin
                if (!in_ack) begin
                    sh_rx   <= {sh_rx[6:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(BITS - 1)) byte_done <= 1'b1;
                end else if (sending) begin
                    host_ack_v <= 1'b1;
                    host_ack   <= ~sda_s;
                end
            end else if (scl_fall) begin
                if (in_ack) begin
                    in_ack  <= 1'b0;
                    bit_cnt <= '0;
                    if (tx_next) begin
                        sending <= 1'b1;
                        sh_tx   <= tx_byte;
                        drive   <= ~tx_byte[7];
                    end else begin
                        sending <= 1'b0;
                        drive   <= 1'b0;
                    end
                end else if (bit_cnt == CNT_W'(BITS)) begin
                    in_ack <= 1'b1;
                    drive  <= sending ? 1'b0 : ack_req;
                end else if (sending && bit_cnt != '0) begin
                    drive <= ~sh_tx[6];
                    sh_tx <= {sh_tx[6:0], 1'b0};
                end
            end
        end
    end

    assign rx_byte = sh_rx;
    assign sda_oe  = drive;

endmodule

// File: rtl/smb_proto.sv
// Module: smb_proto
// Runs the transfer sequence: address match, start index, write count, write
// data, and on reads the length byte followed by register data. It decides the
// acknowledge for each received byte and keeps the running index.
// Assumes: NREGS is a power of two, and the bit engine supplies single-cycle
// byte_done and host_ack_v strobes.
module smb_proto
    import smb_pkg::*;
#(
    parameter int         NREGS   = 16,
    parameter logic [6:0] DEV_ID7 = 7'h69,
    localparam int        IDX_W   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             byte_done,
    input  logic [7:0]       rx_byte,
    input  logic             host_ack_v,
    input  logic             host_ack,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_val,
    output logic             ack_req,
    output logic             tx_next,
    output logic [7:0]       tx_byte,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx
);
    localparam logic [7:0] ADDR_WR = {DEV_ID7, 1'b0};
    localparam logic [7:0] ADDR_RD = {DEV_ID7, 1'b1};

    phase_t           phase;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic [7:0]       left;
    logic [IDX_W-1:0] idx_inc;

    assign idx_inc = idx + 1'b1;

    // Transfer sequencing, acknowledge decisions and write requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            idx_ok  <= 1'b0;
            left    <= '0;
            ack_req <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                phase   <= PH_IDLE;
                ack_req <= 1'b0;
            end else if (start_det) begin
                phase   <= PH_ADDR;
                ack_req <= 1'b0;
            end else if (byte_done) begin
                unique case (phase)
                    PH_ADDR: begin
                        if (rx_byte == ADDR_WR) begin
                            phase   <= PH_INDEX;
                            ack_req <= 1'b1;
                        end else if (rx_byte == ADDR_RD) begin
                            phase   <= PH_TXCNT;
                            ack_req <= 1'b1;
                        end else begin
                            phase   <= PH_SKIP;
                            ack_req <= 1'b0;
                        end
                    end
                    PH_INDEX: begin
                        idx     <= rx_byte[IDX_W-1:0];
                        idx_ok  <= (rx_byte < 8'(NREGS));
                        ack_req <= 1'b1;
                        phase   <= PH_COUNT;
                    end
                    PH_COUNT: begin
                        left    <= rx_byte;
                        ack_req <= 1'b1;
                        phase   <= PH_WDATA;
                    end
                    PH_WDATA: begin
                        if (left != 8'd0) begin
                            ack_req <= 1'b1;
                            left    <= left - 1'b1;
                            idx     <= idx_inc;
                            wr_en   <= idx_ok;
                            wr_idx  <= idx;
                            wr_data <= rx_byte;
                        end else begin
                            ack_req <= 1'b0;
                            phase   <= PH_SKIP;
                        end
                    end
                    default: ack_req <= 1'b0;
                endcase
            end else if (host_ack_v) begin
                if (phase == PH_TXCNT) begin
                    phase <= host_ack ? PH_TXDATA : PH_SKIP;
                end else if (phase == PH_TXDATA) begin
                    if (host_ack) idx   <= idx_inc;
                    else          phase <= PH_SKIP;
                end
            end
        end
    end

    // Choose the next outgoing byte: the length byte first, then register data.
    always_comb begin
        tx_next = (phase == PH_TXCNT) || (phase == PH_TXDATA);
        if (phase == PH_TXCNT) tx_byte = cnt_val;
        else if (idx_ok)       tx_byte = rd_data;
        else                   tx_byte = 8'h00;
    end

    assign rd_idx = idx;

endmodule

// File: rtl/smb_regfile.sv
// Module: smb_regfile
// Holds the byte registers, with one synchronous write port and one
// combinational read port. It exposes the length register separately and all
// registers in parallel.
// Assumes: the write index is always inside the bank.
module smb_regfile #(
    parameter int         NREGS     = 16,
    parameter int         CNT_IDX   = 8,
    parameter logic [7:0] CNT_RESET = 8'h08,
    localparam int        IDX_W     = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [7:0]         rd_data,
    output logic [7:0]         cnt_val,
    output logic [NREGS*8-1:0] cfg_flat
);
    logic [7:0] regs [NREGS];

    // One storage byte per register, each with its own reset value.
    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        localparam logic [7:0] RST_V = (k == CNT_IDX) ? CNT_RESET : 8'h00;

        // Load the register when the write port targets it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                       regs[k] <= RST_V;
            else if (wr_en && wr_idx == IDX_W'(k))            regs[k] <= wr_data;
        end

        assign cfg_flat[8*k +: 8] = regs[k];
    end

    assign rd_data = regs[rd_idx];
    assign cnt_val = regs[CNT_IDX];

endmodule

// File: rtl/smb_regbank.sv
// Module: smb_regbank (top)
// Serial-bus target that gives indexed block access to a bank of byte
// registers. It contains the line synchronizer, the bit engine, the protocol
// engine and the register file.
// Assumes: the external bus has a pull-up on SDA and this block drives SDA
// only through sda_oe. No clock stretching takes place.
module smb_regbank #(
    parameter int         NREGS     = 16,
    parameter int         CNT_IDX   = 8,
    parameter logic [7:0] CNT_RESET = 8'h08,
    parameter logic [6:0] DEV_ID7   = 7'h69,
    parameter int         SYNC_LEN  = 2,
    localparam int        IDX_W     = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [NREGS*8-1:0] cfg_flat
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             byte_done, host_ack_v, host_ack, ack_req, tx_next, wr_en;
    logic [7:0]       rx_byte, tx_byte, wr_data, rd_data, cnt_val;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    smb_line_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_bit_engine u_bits (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .ack_req(ack_req), .tx_next(tx_next), .tx_byte(tx_byte),
        .byte_done(byte_done), .rx_byte(rx_byte), .host_ack_v(host_ack_v),
        .host_ack(host_ack), .sda_oe(sda_oe)
    );

    smb_proto #(.NREGS(NREGS), .DEV_ID7(DEV_ID7)) u_proto (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .byte_done(byte_done), .rx_byte(rx_byte), .host_ack_v(host_ack_v),
        .host_ack(host_ack), .rd_data(rd_data), .cnt_val(cnt_val),
        .ack_req(ack_req), .tx_next(tx_next), .tx_byte(tx_byte),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx)
    );

    smb_regfile #(.NREGS(NREGS), .CNT_IDX(CNT_IDX), .CNT_RESET(CNT_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .cnt_val(cnt_val), .cfg_flat(cfg_flat)
    );

endmodule

// File: rtl/smb_regbank_chk.sv
// Module: smb_regbank_chk
// Property checker for smb_regbank, attached through bind below.
// Assumes: connected to the internal nets named in the bind statement.
module smb_regbank_chk #(
    parameter int IDX_W   = 4,
    parameter int CNT_IDX = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             start_det,
    input logic             stop_det,
    input logic             byte_done,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [7:0]       cnt_val
);
    // R9: the drive enable moves only while the synchronized clock is low.
    assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R10: a register store follows a completed byte.
    assert_store_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_done));

    // R10: start and stop are never reported together.
    assert_one_condition_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det}));

    // R6: after a stop the data line is released.
    assert_release_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R7: the length register changes only through a store aimed at it.
    assert_len_by_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val != $past(cnt_val)) |-> $past(wr_en && wr_idx == IDX_W'(CNT_IDX)));

endmodule

bind smb_regbank smb_regbank_chk #(.IDX_W(IDX_W), .CNT_IDX(CNT_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .start_det(start_det), .stop_det(stop_det), .byte_done(byte_done),
    .wr_en(wr_en), .wr_idx(wr_idx), .cnt_val(cnt_val)
);

// File: tb/smb_regbank_tb.sv
// Bench for smb_regbank: bit-banged host, register model, directed corner
// cases plus seeded random transfers.
module smb_regbank_tb;
    localparam int Q = 6;
    localparam int H = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_host = 1'b1;
    logic         sda_bus;
    logic         sda_oe;
    logic [127:0] cfg_flat;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [7:0] mreg [16];
    logic [7:0] wbuf [8];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_host & ~sda_oe;

    smb_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .cfg_flat(cfg_flat)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int n, input int j);
        return (n < 16) ? mreg[(n + j) % 16] : 8'h00;
    endfunction

    task automatic bus_start();
        sda_host = 1'b1; tick(Q); scl = 1'b1; tick(H);
        sda_host = 1'b0; tick(H); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; tick(Q); scl = 1'b1; tick(H);
        sda_host = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_host = b[i]; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
        end
        sda_host = 1'b1; tick(Q); scl = 1'b1; tick(H / 2);
        acked = ~sda_bus;
        tick(H / 2); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_host = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(H / 2); b[i] = sda_bus;
            tick(H / 2); scl = 1'b0; tick(Q);
        end
        sda_host = ~give_ack; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
        sda_host = 1'b1;
    endtask

    // Full write: address, index n, count x, then nsend bytes from wbuf.
    task automatic do_write(input int n, input int x, input int nsend);
        bit a;
        bus_start();
        send_byte(8'hD2, a); check(a, "R1 write address ack", a, 1);
        send_byte(8'(n), a); check(a, "R2/R4 index ack", a, 1);
        send_byte(8'(x), a); check(a, "R2 count ack", a, 1);
        for (int k = 0; k < nsend; k++) begin
            send_byte(wbuf[k], a);
            check(a == (k < x), "R2/R5 data ack", a, int'(k < x));
            if (k < x && n < 16) mreg[(n + k) % 16] = wbuf[k];
        end
        bus_stop();
    endtask

    // Full read: index phase, repeated start, length byte, len data bytes.
    task automatic do_read(input int n, input int len);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a); check(a, "R6 index-phase address ack", a, 1);
        send_byte(8'(n), a); check(a, "R6 index ack", a, 1);
        sda_host = 1'b1; tick(Q); scl = 1'b1; tick(H); sda_host = 1'b0; tick(H);
        scl = 1'b0; tick(Q);
        send_byte(8'hD3, a); check(a, "R1 read address ack", a, 1);
        recv_byte(1'b1, b); check(b == mreg[8], "R7 length byte", b, mreg[8]);
        for (int j = 0; j < len; j++) begin
            recv_byte(j != len - 1, b);
            check(b == exp_read(n, j), "R6/R3/R4 read data", b, exp_read(n, j));
        end
        // After the host NACK the target must stay released for a whole byte.
        for (int i = 0; i < 9; i++) begin
            tick(Q); scl = 1'b1; tick(H / 2);
            if (sda_oe) check(1'b0, "R6 release after NACK", 1, 0);
            tick(H / 2); scl = 1'b0; tick(Q);
        end
        bus_stop();
    endtask

    task automatic check_cfg(input string req);
        for (int k = 0; k < 16; k++)
            check(cfg_flat[8*k +: 8] == mreg[k], req, cfg_flat[8*k +: 8], mreg[k]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit a;
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < 16; k++) mreg[k] = (k == 8) ? 8'h08 : 8'h00;
        tick(8); rst_n = 1'b1; tick(8);

        // R8: reset state.
        check(sda_oe == 1'b0, "R8 released after reset", sda_oe, 0);
        check_cfg("R8/R11 reset contents");
        do_read(6, 4);

        // R2/R11: plain write then parallel output.
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'h31 + k * 8'h11);
        do_write(2, 5, 5);
        check_cfg("R11 parallel output after write");

        // R3: wrapping write and read.
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
        do_write(14, 4, 4);
        do_read(15, 3);

        // R4: out-of-range index.
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
        do_write(8'h20, 2, 2);
        check_cfg("R4 discarded write");
        do_read(8'h41, 2);

        // R5: bytes beyond count, and zero count.
        wbuf[0] = 8'h5C; wbuf[1] = 8'h6D; wbuf[2] = 8'h7E;
        do_write(9, 1, 3);
        do_write(10, 0, 1);
        check_cfg("R5 overflow bytes not stored");

        // R7: reprogram the length register.
        wbuf[0] = 8'h03;
        do_write(8, 1, 1);
        do_read(7, 2);

        // R1: foreign address is ignored until the next start.
        bus_start();
        send_byte(8'hA4, a); check(!a, "R1 foreign address NACK", a, 0);
        send_byte(8'h00, a); check(!a, "R1 ignored index", a, 0);
        send_byte(8'h01, a); check(!a, "R1 ignored count", a, 0);
        send_byte(8'hFF, a); check(!a, "R1 ignored data", a, 0);
        bus_stop();
        check_cfg("R1 nothing stored");

        // R10: stop inside a byte after one complete byte.
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h04, a); send_byte(8'h02, a);
        send_byte(8'h99, a); check(a, "R10 first byte ack", a, 1);
        mreg[4] = 8'h99;
        for (int i = 7; i >= 4; i--) begin
            sda_host = 1'b0; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
        end
        bus_stop();
        check_cfg("R10 stop mid-byte");

        // R10: repeated start inside a byte, then a normal write.
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h0C, a); send_byte(8'h03, a);
        for (int i = 7; i >= 5; i--) begin
            sda_host = 1'b1; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
        end
        sda_host = 1'b1; tick(Q); scl = 1'b1; tick(H); sda_host = 1'b0; tick(H);
        scl = 1'b0; tick(Q);
        send_byte(8'hD2, a); check(a, "R10 address after abort", a, 1);
        send_byte(8'h0C, a); send_byte(8'h01, a);
        send_byte(8'h77, a); check(a, "R10 data after abort", a, 1);
        mreg[12] = 8'h77;
        bus_stop();
        check_cfg("R10 start mid-byte");

        // Seeded random traffic.
        for (int t = 0; t < 14; t++) begin
            int n, x, ns;
            n  = ($urandom % 8 == 0) ? 16 + int'($urandom % 200) : int'($urandom % 16);
            x  = int'($urandom % 5);
            ns = x + (($urandom % 4 == 0) ? 1 : 0);
            for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
            do_write(n, x, ns);
            do_read(int'($urandom % 16), 1 + int'($urandom % 5));
        end
        check_cfg("R11 final contents");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule